// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps the time of day and the calendar in packed BCD registers. The finest field is the hundredth of a second. A reference strobe arrives at a nominal 32.768 kHz rate. An internal fractional accumulator turns that strobe into an exact-average 100 Hz advance tick. Each tick adds one hundredth. Carries then ripple through seconds, minutes, hours, day of week, date, month and year. Month lengths and leap years are handled.

Software reads and loads the fields over a small parallel register bus. The bus has a 6-bit address, an 8-bit write path and a combinational read path. Loading any time field also restarts the sub-hundredth accumulator, so counting resumes from a clean phase.

The hour field can run in a 24-hour encoding or in a 12-hour encoding with a PM flag. The top bit of the date field is a general-purpose control flag. It plays no part in counting and is brought out on its own pin.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the fields read hundredths 0x00, seconds 0x00, minutes 0x00, hour 0x00 (24-hour mode), weekday 0x01, date 0x01, month 0x01, year 0x00, and date_flag is 0.
- R2: Each ref_pulse adds TICK_HZ to an accumulator. When the sum reaches REF_HZ, REF_HZ is subtracted and tick_100 is high for that pulse. So N pulses after a clear give floor(N*TICK_HZ/REF_HZ) ticks.
- R3: Address 0 holds tenths:hundredths, address 1 holds seconds and address 2 holds minutes, all BCD with the tens digit in the upper nibble. Each tick advances hundredths. 99 wraps to 00 and carries to seconds. Seconds and minutes wrap 59 to 00 and carry onward.
- R4: Address 3 is the hour. Bit 6 = 1 selects 12-hour mode. In 24-hour mode, bits 5:0 are BCD 00–23, and 23 rolls to 00 with a day carry.
- R5: In 12-hour mode, bit 5 is PM and bits 4:0 are BCD 01–12. Going from 11 to 12 toggles PM. Going from 12 to 01 leaves PM unchanged. A day carry happens only on the 11 PM to 12 AM step.
- R6: Address 4 is the weekday, BCD 01–07. It advances on each day carry, and 07 wraps to 01.
- R7: Address 5 bits 5:0 hold the BCD date. At the last day of the month the date wraps to 01 and carries to the month. Months 04, 06, 09 and 11 have 30 days; the other non-February months have 31.
- R8: February has 29 days when the year value is divisible by 4, including 00, and 28 days otherwise.
- R9: Address 6 is the BCD month 01–12, and 12 wraps to 01 with a carry into the year. Address 7 is the BCD year, and 99 wraps to 00.
- R10: Bit 7 of address 5 is a control flag. It is driven on date_flag, is not counted, and keeps its value across date rollovers. Only a write to address 5 changes it.
- R11: A write to addresses 0–7 loads that field and clears the accumulator, and no field advances in that cycle. A write to any other address has no effect on the fields. Reads of other addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_pulse | input | 1 | One-cycle strobe at the reference rate |
| bus_we | input | 1 | Register write enable |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| tick_100 | output | 1 | High in the cycle the time advances by one hundredth |
| date_flag | output | 1 | Control flag held in the date register MSB |

## Verification
The bench builds the block with REF_HZ=7 and TICK_HZ=3. With these values the accumulator's fractional pattern (ticks on the 3rd, 5th and 7th pulse of every seven) shows up within a handful of pulses. Every calendar carry is then only a few strobes away once a field has been loaded near its limit. Random loads biased toward field maxima, together with directed midnight, noon, month-end, leap and year-end cases, cover 12-hour and 24-hour rollovers across all month lengths.

// File: rtl/bcd_rtc.sv
module bcd_rtc #(
  parameter int REF_HZ  = 32768,
  parameter int TICK_HZ = 100,
  localparam int ACC_W  = $clog2(REF_HZ + TICK_HZ)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_pulse,
  input  logic       bus_we,
  input  logic [5:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       tick_100,
  output logic       date_flag
);

  function automatic logic [7:0] inc_bcd(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] to_bin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   acc_sum;
  logic             ovf, wr_time;
  logic [7:0]       hs, sec, min, hour, dow, date, mon, yr;

  assign acc_sum  = {1'b0, acc} + (ACC_W+1)'(TICK_HZ);
  assign ovf      = acc_sum >= (ACC_W+1)'(REF_HZ);
  assign wr_time  = bus_we && (bus_addr < 6'd8);
  assign tick_100 = ref_pulse && !wr_time && ovf;
  assign date_flag = date[7];

  logic [7:0] h12_inc, h24_inc, d_inc;
  logic [6:0] yr_bin, date_bin;
  logic [4:0] last_day;
  logic       c1, c2, c3, day_c, c5, c6;
  logic [7:0] hour_n;

  assign h12_inc  = inc_bcd({3'b0, hour[4:0]});
  assign h24_inc  = inc_bcd({2'b0, hour[5:0]});
  assign d_inc    = inc_bcd({2'b0, date[5:0]});
  assign yr_bin   = to_bin(yr);
  assign date_bin = to_bin({2'b0, date[5:0]});

  always_comb begin
    case (mon)
      8'h02:                      last_day = (yr_bin[1:0] == 2'b00) ? 5'd29 : 5'd28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 5'd30;
      default:                    last_day = 5'd31;
    endcase
  end

  assign c1 = tick_100 && (hs == 8'h99);
  assign c2 = c1 && (sec == 8'h59);
  assign c3 = c2 && (min == 8'h59);

  always_comb begin
    hour_n = hour;
    day_c  = 1'b0;
    if (c3) begin
      if (hour[6]) begin
        if (hour[4:0] == 5'h12) hour_n = {hour[7:5], 5'h01};
        else if (hour[4:0] == 5'h11) begin
          hour_n = {hour[7:6], ~hour[5], 5'h12};
          day_c  = hour[5];
        end else hour_n = {hour[7:5], h12_inc[4:0]};
      end else begin
        if (hour[5:0] == 6'h23) begin
          hour_n = {hour[7:6], 6'h00};
          day_c  = 1'b1;
        end else hour_n = {hour[7:6], h24_inc[5:0]};
      end
    end
  end

  assign c5 = day_c && (date_bin >= {2'b0, last_day});
  assign c6 = c5 && (mon == 8'h12);

  always_ff @(posedge clk) begin
    if (!rst_n) acc <= '0;
    else if (wr_time) acc <= '0;
    else if (ref_pulse) acc <= ovf ? ACC_W'(acc_sum - (ACC_W+1)'(REF_HZ)) : acc_sum[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs <= 8'h00; sec <= 8'h00; min <= 8'h00; hour <= 8'h00;
      dow <= 8'h01; date <= 8'h01; mon <= 8'h01; yr <= 8'h00;
    end else if (wr_time) begin
      case (bus_addr[2:0])
        3'd0: hs   <= bus_wdata;
        3'd1: sec  <= {1'b0, bus_wdata[6:0]};
        3'd2: min  <= {1'b0, bus_wdata[6:0]};
        3'd3: hour <= {1'b0, bus_wdata[6:0]};
        3'd4: dow  <= {5'b0, bus_wdata[2:0]};
        3'd5: date <= {bus_wdata[7], 1'b0, bus_wdata[5:0]};
        3'd6: mon  <= {3'b0, bus_wdata[4:0]};
        default: yr <= bus_wdata;
      endcase
    end else if (tick_100) begin
      hs   <= c1 ? 8'h00 : inc_bcd(hs);
      hour <= hour_n;
      if (c1) sec <= c2 ? 8'h00 : inc_bcd(sec);
      if (c2) min <= c3 ? 8'h00 : inc_bcd(min);
      if (day_c) begin
        dow  <= (dow == 8'h07) ? 8'h01 : dow + 8'h01;
        date <= {date[7:6], c5 ? 6'h01 : d_inc[5:0]};
      end
      if (c5) mon <= c6 ? 8'h01 : inc_bcd(mon);
      if (c6) yr  <= (yr == 8'h99) ? 8'h00 : inc_bcd(yr);
    end
  end

  always_comb begin
    case (bus_addr)
      6'd0: bus_rdata = hs;
      6'd1: bus_rdata = sec;
      6'd2: bus_rdata = min;
      6'd3: bus_rdata = hour;
      6'd4: bus_rdata = dow;
      6'd5: bus_rdata = date;
      6'd6: bus_rdata = mon;
      6'd7: bus_rdata = yr;
      default: bus_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/bcd_rtc_chk.sv
module bcd_rtc_chk #(
  parameter int ACC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_pulse,
  input logic             bus_we,
  input logic [5:0]       bus_addr,
  input logic             tick_100,
  input logic             date_flag,
  input logic [ACC_W-1:0] acc,
  input logic [7:0]       hs,
  input logic [7:0]       sec,
  input logic [7:0]       min,
  input logic [7:0]       hour,
  input logic [7:0]       dow
);

  // R2
  tick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_100 |-> ref_pulse);

  // R3
  hs_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_100 && hs == 8'h99) |=> hs == 8'h00);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_100 && !bus_we) |=> ($stable(sec) && $stable(min) && $stable(hour)));

  // R4
  midnight24_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_100 && hs == 8'h99 && sec == 8'h59 && min == 8'h59 && hour == 8'h23)
      |=> (hour == 8'h00 && dow != $past(dow)));

  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == 6'd5) |=> date_flag == $past(date_flag));

  // R11
  wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr < 6'd8) |=> acc == '0);

endmodule

bind bcd_rtc bcd_rtc_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .bus_we(bus_we),
  .bus_addr(bus_addr), .tick_100(tick_100), .date_flag(date_flag),
  .acc(acc), .hs(hs), .sec(sec), .min(min), .hour(hour), .dow(dow)
);

// File: tb/bcd_rtc_test.sv
module bcd_rtc_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_pulse = 1'b0;
  logic       bus_we = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       tick_100, date_flag;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  bcd_rtc #(.REF_HZ(7), .TICK_HZ(3)) uut (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_100(tick_100), .date_flag(date_flag)
  );

  always #4 clk = ~clk;

  int m_hs, m_s, m_m, m_h, m_dw, m_dt, m_mo, m_yr, m_12, m_fl;

  function automatic int bcd(int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic int mdays(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic int exp_reg(int a);
    int h12;
    case (a)
      0: return bcd(m_hs);
      1: return bcd(m_s);
      2: return bcd(m_m);
      3: begin
        if (m_12 == 0) return bcd(m_h);
        h12 = (m_h % 12 == 0) ? 12 : m_h % 12;
        return 8'h40 | ((m_h >= 12) ? 8'h20 : 0) | bcd(h12);
      end
      4: return m_dw;
      5: return (m_fl << 7) | bcd(m_dt);
      6: return bcd(m_mo);
      7: return bcd(m_yr);
      default: return 0;
    endcase
  endfunction

  task automatic model_tick();
    m_hs++;
    if (m_hs < 100) return;
    m_hs = 0; m_s++;
    if (m_s < 60) return;
    m_s = 0; m_m++;
    if (m_m < 60) return;
    m_m = 0; m_h++;
    if (m_h < 24) return;
    m_h = 0;
    m_dw = (m_dw == 7) ? 1 : m_dw + 1;
    m_dt++;
    if (m_dt <= mdays(m_mo, m_yr)) return;
    m_dt = 1; m_mo++;
    if (m_mo <= 12) return;
    m_mo = 1; m_yr = (m_yr + 1) % 100;
  endtask

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output int v);
    @(negedge clk);
    bus_addr = a;
    #1 v = int'(bus_rdata);
  endtask

  task automatic pulse(output bit t);
    @(negedge clk);
    ref_pulse = 1'b1;
    #1 t = tick_100;
    @(negedge clk);
    ref_pulse = 1'b0;
  endtask

  task automatic pulses(int n, output int ticks);
    bit t;
    ticks = 0;
    for (int i = 0; i < n; i++) begin
      pulse(t);
      ticks += int'(t);
    end
  endtask

  task automatic advance_one();
    bit t;
    t = 0;
    for (int i = 0; i < 8 && !t; i++) pulse(t);
  endtask

  task automatic load_model();
    for (int a = 0; a < 8; a++) wr(6'(a), 8'(exp_reg(a)));
  endtask

  task automatic check_all(string req);
    int v;
    for (int a = 0; a < 8; a++) begin
      rd(6'(a), v);
      check(req, v, exp_reg(a));
    end
    check(req, int'(date_flag), m_fl);
  endtask

  task automatic set_t(int h, int mi, int s, int hs, int dw, int dt, int mo, int yr, int m12, int fl);
    m_h = h; m_m = mi; m_s = s; m_hs = hs; m_dw = dw; m_dt = dt;
    m_mo = mo; m_yr = yr; m_12 = m12; m_fl = fl;
  endtask

  task automatic step_case(string req);
    load_model();
    advance_one();
    model_tick();
    check_all(req);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v, tk;
    int unsigned seed;
    seed = $urandom(1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    set_t(0, 0, 0, 0, 1, 1, 1, 0, 0, 0);
    check_all("R1");

    // R2 fractional division: 3 ticks per 7 pulses
    wr(6'd0, 8'h00);
    pulses(7, tk);
    check("R2", tk, 3);
    pulses(7, tk);
    check("R2", tk, 3);
    rd(6'd0, v);
    check("R2", v, 8'h06);

    // R11 write clears accumulator
    pulses(2, tk);
    check("R11", tk, 0);
    wr(6'd0, 8'h40);
    pulses(1, tk);
    check("R11", tk, 0);
    pulses(2, tk);
    check("R11", tk, 1);
    rd(6'd0, v);
    check("R11", v, 8'h41);

    // R11 unmapped writes ignored
    set_t(13, 27, 45, 12, 3, 15, 8, 42, 0, 1);
    load_model();
    wr(6'd9, 8'hFF);
    wr(6'h3F, 8'h55);
    check_all("R11");
    rd(6'd9, v);
    check("R11", v, 0);

    // R3 seconds/minutes carry
    set_t(5, 59, 59, 99, 2, 10, 3, 10, 0, 0);
    step_case("R3");
    // R4 24-hour midnight
    set_t(23, 59, 59, 99, 4, 10, 3, 10, 0, 0);
    step_case("R4");
    // R5 12-hour: 11 AM -> 12 PM, 12 PM -> 1 PM, 11 PM -> 12 AM
    set_t(11, 59, 59, 99, 4, 10, 3, 10, 1, 0);
    step_case("R5");
    set_t(12, 59, 59, 99, 4, 10, 3, 10, 1, 0);
    step_case("R5");
    set_t(23, 59, 59, 99, 4, 10, 3, 10, 1, 0);
    step_case("R5");
    set_t(0, 59, 59, 99, 4, 10, 3, 10, 1, 0);
    step_case("R5");
    // R6 weekday wrap
    set_t(23, 59, 59, 99, 7, 10, 3, 10, 0, 0);
    step_case("R6");
    // R7 month lengths
    set_t(23, 59, 59, 99, 1, 30, 4, 10, 0, 0);
    step_case("R7");
    set_t(23, 59, 59, 99, 1, 30, 5, 10, 0, 0);
    step_case("R7");
    set_t(23, 59, 59, 99, 1, 30, 11, 10, 0, 0);
    step_case("R7");
    // R8 February
    set_t(23, 59, 59, 99, 1, 28, 2, 24, 0, 0);
    step_case("R8");
    set_t(23, 59, 59, 99, 1, 28, 2, 23, 0, 0);
    step_case("R8");
    set_t(23, 59, 59, 99, 1, 29, 2, 0, 0, 0);
    step_case("R8");
    // R9 year end
    set_t(23, 59, 59, 99, 1, 31, 12, 99, 0, 0);
    step_case("R9");
    // R10 flag across rollover
    set_t(23, 59, 59, 99, 1, 31, 1, 5, 1, 1);
    step_case("R10");

    // R3 random mix with corner bias
    for (int it = 0; it < 60; it++) begin
      m_hs = ($urandom % 2) ? 99 : $urandom % 100;
      m_s  = ($urandom % 2) ? 59 : $urandom % 60;
      m_m  = ($urandom % 2) ? 59 : $urandom % 60;
      case ($urandom % 4)
        0: m_h = 23;
        1: m_h = 11;
        2: m_h = 12;
        default: m_h = $urandom % 24;
      endcase
      m_12 = $urandom % 2;
      m_dw = ($urandom % 2) ? 7 : 1 + $urandom % 7;
      m_mo = 1 + $urandom % 12;
      m_yr = ($urandom % 3 == 0) ? 99 : $urandom % 100;
      m_dt = ($urandom % 2) ? mdays(m_mo, m_yr) : 1 + $urandom % mdays(m_mo, m_yr);
      m_fl = $urandom % 2;
      step_case("R3 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule